// File: doc/BRIEF.md
# DRAM Address Multiplexer and Open-Page Tracker

This block sits between a memory scheduler and the DRAM pins. The scheduler hands it a physical address together with the memory rank that address already decodes to. From that rank's configuration the block splits the address into column, internal-bank and page-row fields: whether the rank is EDO or SDRAM, its column width, and whether it is built from 16 Mb or 64 Mb devices. It then forms the values that go out on the 14-bit multiplexed address bus during the row phase and the column phase.

The block also records which page is open in each bank of each rank. Every request is answered one cycle later with a page hit, a page miss or an idle bank, so the scheduler can choose between a plain column access, a precharge followed by an activate, or an activate alone. The scheduler sends open, close-bank and close-rank commands to keep this record current. The one-page limit for EDO memory is enforced here: opening an EDO page closes every other page in the system, and opening an SDRAM page closes any EDO page.

Top module: `dram_pagemux`

## Requirements
- R1: A synchronous active-low reset clears every tracked page, so `open_map` reads zero and the first request after reset reports idle (status 0).
- R2: The address is split from the LSB upward. Bits 2:0 are a byte offset and are dropped. Next come C column bits, then K bank bits, then W page-row bits. C is 8, 9 or 10 for SDRAM column codes 0, 1 and 2, and always 8 for EDO. K is 1 for 16 Mb SDRAM, 2 for 64 Mb SDRAM and 0 for EDO. W is 11 or 12 for 16 Mb or 64 Mb SDRAM, and 12 or 14 for 16 Mb or 64 Mb EDO. Higher bits are ignored.
- R3: The row-phase value carries the page row from MA[0] upward. The column-phase value carries the column from MA[0] upward. For SDRAM, both values carry bank bit 0 on MA[12] and bank bit 1 on MA[13]. Every other bit is zero.
- R4: Each request (`req_valid` high) yields exactly one response, with `rsp_valid` high, on the following cycle. No response appears without a request.
- R5: Status encoding: 0 means idle (no page open in that bank), 1 means hit (a page is open with the same row), and 2 means miss (a page is open with a different row).
- R6: An open command (op 1) records the row in the addressed bank of the addressed rank. The other banks of an SDRAM rank keep their state, so 16 Mb ranks hold up to two open pages and 64 Mb ranks up to four.
- R7: An open command to an EDO rank closes every other page in all ranks, leaving exactly one page open.
- R8: An open command to an SDRAM rank closes any page held by an EDO rank.
- R9: Op 2 closes only the addressed bank. Op 3 closes every bank of the addressed rank. Op 0 changes nothing.
- R10: A request in the same cycle as a command is answered from the page state before that command.
- R11: `open_map` bit 4*rank+bank is high exactly while that bank holds an open page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_sdram | input | NUM_RANKS | Per rank: 1 = SDRAM, 0 = EDO |
| cfg_dens64 | input | NUM_RANKS | Per rank: 1 = 64 Mb devices, 0 = 16 Mb |
| cfg_col | input | 2*NUM_RANKS | Per rank column code (bits 2r+1:2r) |
| req_valid | input | 1 | Lookup request strobe |
| req_rank | input | RANK_W | Rank the request decodes to |
| req_addr | input | ADDR_W | Request physical address |
| cmd_valid | input | 1 | Page command strobe |
| cmd_op | input | 2 | 0 none, 1 open, 2 close bank, 3 close rank |
| cmd_rank | input | RANK_W | Rank the command targets |
| cmd_addr | input | ADDR_W | Address giving the bank and row of the command |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_status | output | 2 | 0 idle, 1 hit, 2 miss |
| rsp_bank | output | 2 | Internal bank of the request |
| rsp_ma_row | output | 14 | Row-phase multiplexed address |
| rsp_ma_col | output | 14 | Column-phase multiplexed address |
| open_map | output | 4*NUM_RANKS | Open-page flags, bit 4*rank+bank |

## Verification
The bench drives ranks of every kind: EDO and SDRAM, both densities, and all three column widths. A wrong field boundary in any of them shows up as a shifted row or column on the bus, or as a bank bit landing in the row. It fills all four banks of a 64 Mb rank and two of a 16 Mb rank. A tracker that shared one slot per rank would report misses or idles where hits belong. It alternates EDO and SDRAM opens; a design that skipped the system-wide clear would leave two pages open and expose them in `open_map`. It also issues a request and an open to the same page in one cycle. A design that forwarded the command would answer hit where idle is required.

// File: rtl/dram_pagemux_pkg.sv
// Shared types and field-width rules for the DRAM address multiplexer.
// Assumes column codes 0/1/2 select 8/9/10 column bits; code 3 is treated as 10.
package dram_pagemux_pkg;

    typedef enum logic [1:0] {
        PG_IDLE = 2'd0,
        PG_HIT  = 2'd1,
        PG_MISS = 2'd2
    } pg_status_e;

    typedef enum logic [1:0] {
        OP_NONE       = 2'd0,
        OP_OPEN       = 2'd1,
        OP_CLOSE_BANK = 2'd2,
        OP_CLOSE_RANK = 2'd3
    } pg_op_e;

    typedef struct packed {
        logic       is_sdram;
        logic       dens64;
        logic [1:0] col_code;
    } rank_cfg_t;

    // Column field width for a rank.
    function automatic int unsigned col_bits(rank_cfg_t c);
        if (!c.is_sdram)           return 8;
        else if (c.col_code == 2'd0) return 8;
        else if (c.col_code == 2'd1) return 9;
        else                        return 10;
    endfunction

    // Internal-bank field width for a rank.
    function automatic int unsigned bank_bits(rank_cfg_t c);
        if (!c.is_sdram) return 0;
        return c.dens64 ? 2 : 1;
    endfunction

    // Page-row field width for a rank.
    function automatic int unsigned row_bits(rank_cfg_t c);
        if (!c.is_sdram) return c.dens64 ? 14 : 12;
        return c.dens64 ? 12 : 11;
    endfunction

endpackage

// File: rtl/dram_addr_split.sv
// Splits a physical address into column, bank and page-row fields for one
// rank and forms the row-phase and column-phase bus values.
// Assumes ADDR_W covers offset + widest column + bank + row (29 bits) and
// MA_W >= 14 so the bank bits sit on the two top bus lines.
module dram_addr_split
    import dram_pagemux_pkg::*;
#(
    parameter int ADDR_W = 29,
    parameter int MA_W   = 14,
    parameter int ROW_W  = 14
) (
    input  rank_cfg_t          cfg,
    input  logic [ADDR_W-1:0]  addr,
    output logic [ROW_W-1:0]   page_row,
    output logic [1:0]         bank,
    output logic [MA_W-1:0]    ma_row,
    output logic [MA_W-1:0]    ma_col
);
    localparam int OFFS_W = 3;

    function automatic logic [ADDR_W-1:0] low_mask(int unsigned n);
        return ~({ADDR_W{1'b1}} << n);
    endfunction

    logic [ADDR_W-1:0] after_offs, after_col, after_bank;
    logic [ADDR_W-1:0] col_full;
    logic [MA_W-1:0]   bank_lines;

    // Peel the fields off from the least significant end.
    always_comb begin
        after_offs = addr >> OFFS_W;
        col_full   = after_offs & low_mask(col_bits(cfg));
        after_col  = after_offs >> col_bits(cfg);
        bank       = 2'(after_col & low_mask(bank_bits(cfg)));
        after_bank = after_col >> bank_bits(cfg);
        page_row   = ROW_W'(after_bank & low_mask(row_bits(cfg)));
    end

    // Place the bank bits on the two highest bus lines, then merge each phase.
    always_comb begin
        bank_lines           = '0;
        bank_lines[MA_W-2]   = bank[0];
        bank_lines[MA_W-1]   = bank[1];
        ma_row               = MA_W'(page_row) | bank_lines;
        ma_col               = MA_W'(col_full) | bank_lines;
    end

endmodule

// File: rtl/dram_page_table.sv
// Open-page record: one valid flag and stored row per bank slot per rank.
// Lookups read the state held at the start of the cycle; commands update it
// at the clock edge. Assumes the rank configuration is static while pages
// are open.
module dram_page_table
    import dram_pagemux_pkg::*;
#(
    parameter int NUM_RANKS = 8,
    parameter int SLOTS     = 4,
    parameter int ROW_W     = 14,
    localparam int RANK_W   = $clog2(NUM_RANKS),
    localparam int SLOT_W   = $clog2(SLOTS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_RANKS-1:0]     rank_sdram,
    input  logic [RANK_W-1:0]        lk_rank,
    input  logic [SLOT_W-1:0]        lk_bank,
    input  logic [ROW_W-1:0]         lk_row,
    output pg_status_e               lk_status,
    input  logic                     cmd_valid,
    input  pg_op_e                   cmd_op,
    input  logic [RANK_W-1:0]        cmd_rank,
    input  logic [SLOT_W-1:0]        cmd_bank,
    input  logic [ROW_W-1:0]         cmd_row,
    output logic [NUM_RANKS*SLOTS-1:0] open_flags
);
    logic             slot_vld [NUM_RANKS][SLOTS];
    logic [ROW_W-1:0] slot_row [NUM_RANKS][SLOTS];
    logic             cmd_to_sdram;

    // Type of the rank a command targets decides how wide an open clears.
    assign cmd_to_sdram = rank_sdram[cmd_rank];

    for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
        for (genvar s = 0; s < SLOTS; s++) begin : g_slot
            logic is_target;
            logic in_rank;
            assign in_rank   = (cmd_rank == RANK_W'(r));
            assign is_target = in_rank && (cmd_bank == SLOT_W'(s));

            // Maintain one slot's open flag and row under the command stream.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    slot_vld[r][s] <= 1'b0;
                    slot_row[r][s] <= '0;
                end else if (cmd_valid) begin
                    unique case (cmd_op)
                        OP_OPEN: begin
                            if (is_target) begin
                                slot_vld[r][s] <= 1'b1;
                                slot_row[r][s] <= cmd_row;
                            end else if (!cmd_to_sdram || !rank_sdram[r]) begin
                                slot_vld[r][s] <= 1'b0;
                            end
                        end
                        OP_CLOSE_BANK: if (is_target) slot_vld[r][s] <= 1'b0;
                        OP_CLOSE_RANK: if (in_rank)   slot_vld[r][s] <= 1'b0;
                        default: ;
                    endcase
                end
            end

            assign open_flags[r*SLOTS+s] = slot_vld[r][s];
        end
    end

    // Classify a lookup against the addressed slot.
    always_comb begin
        if (!slot_vld[lk_rank][lk_bank])
            lk_status = PG_IDLE;
        else if (slot_row[lk_rank][lk_bank] == lk_row)
            lk_status = PG_HIT;
        else
            lk_status = PG_MISS;
    end

endmodule

// File: rtl/dram_pagemux.sv
// Top of the DRAM address multiplexer and open-page tracker. Splits request
// and command addresses with per-rank settings, looks up the page record and
// registers the result with the bus values one cycle later.
// Assumes ranks index below NUM_RANKS and configuration is held steady.
module dram_pagemux
    import dram_pagemux_pkg::*;
#(
    parameter int NUM_RANKS = 8,
    parameter int ADDR_W    = 29,
    parameter int MA_W      = 14,
    localparam int RANK_W   = $clog2(NUM_RANKS),
    localparam int SLOTS    = 4,
    localparam int ROW_W    = 14,
    localparam int NPORT    = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_RANKS-1:0]       cfg_sdram,
    input  logic [NUM_RANKS-1:0]       cfg_dens64,
    input  logic [2*NUM_RANKS-1:0]     cfg_col,
    input  logic                       req_valid,
    input  logic [RANK_W-1:0]          req_rank,
    input  logic [ADDR_W-1:0]          req_addr,
    input  logic                       cmd_valid,
    input  logic [1:0]                 cmd_op,
    input  logic [RANK_W-1:0]          cmd_rank,
    input  logic [ADDR_W-1:0]          cmd_addr,
    output logic                       rsp_valid,
    output logic [1:0]                 rsp_status,
    output logic [1:0]                 rsp_bank,
    output logic [MA_W-1:0]            rsp_ma_row,
    output logic [MA_W-1:0]            rsp_ma_col,
    output logic [SLOTS*NUM_RANKS-1:0] open_map
);
    rank_cfg_t         rank_cfg [NUM_RANKS];
    logic [RANK_W-1:0] sp_rank  [NPORT];
    logic [ADDR_W-1:0] sp_addr  [NPORT];
    rank_cfg_t         sp_cfg   [NPORT];
    logic [ROW_W-1:0]  sp_row   [NPORT];
    logic [1:0]        sp_bank  [NPORT];
    logic [MA_W-1:0]   sp_ma_r  [NPORT];
    logic [MA_W-1:0]   sp_ma_c  [NPORT];
    pg_status_e        lk_status;

    // Gather each rank's flat configuration bits into one record.
    for (genvar r = 0; r < NUM_RANKS; r++) begin : g_cfg
        assign rank_cfg[r] = '{is_sdram: cfg_sdram[r],
                               dens64:   cfg_dens64[r],
                               col_code: cfg_col[2*r +: 2]};
    end

    // Port 0 is the request path, port 1 the command path.
    assign sp_rank[0] = req_rank;
    assign sp_addr[0] = req_addr;
    assign sp_rank[1] = cmd_rank;
    assign sp_addr[1] = cmd_addr;

    for (genvar p = 0; p < NPORT; p++) begin : g_split
        assign sp_cfg[p] = rank_cfg[sp_rank[p]];
        dram_addr_split #(
            .ADDR_W (ADDR_W),
            .MA_W   (MA_W),
            .ROW_W  (ROW_W)
        ) u_split (
            .cfg      (sp_cfg[p]),
            .addr     (sp_addr[p]),
            .page_row (sp_row[p]),
            .bank     (sp_bank[p]),
            .ma_row   (sp_ma_r[p]),
            .ma_col   (sp_ma_c[p])
        );
    end

    dram_page_table #(
        .NUM_RANKS (NUM_RANKS),
        .SLOTS     (SLOTS),
        .ROW_W     (ROW_W)
    ) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .rank_sdram (cfg_sdram),
        .lk_rank    (req_rank),
        .lk_bank    (sp_bank[0]),
        .lk_row     (sp_row[0]),
        .lk_status  (lk_status),
        .cmd_valid  (cmd_valid),
        .cmd_op     (pg_op_e'(cmd_op)),
        .cmd_rank   (cmd_rank),
        .cmd_bank   (sp_bank[1]),
        .cmd_row    (sp_row[1]),
        .open_flags (open_map)
    );

    // Register the lookup result and bus values for the next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_status <= PG_IDLE;
            rsp_bank   <= '0;
            rsp_ma_row <= '0;
            rsp_ma_col <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_status <= lk_status;
                rsp_bank   <= sp_bank[0];
                rsp_ma_row <= sp_ma_r[0];
                rsp_ma_col <= sp_ma_c[0];
            end
        end
    end

endmodule

// File: rtl/dram_pagemux_chk.sv
// Property checker for dram_pagemux: response timing, status range, page
// capacity per rank type, the EDO single-page rule and close-rank effect.
module dram_pagemux_chk #(
    parameter int NUM_RANKS = 8,
    localparam int RANK_W   = $clog2(NUM_RANKS),
    localparam int SLOTS    = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [NUM_RANKS-1:0]       cfg_sdram,
    input logic [NUM_RANKS-1:0]       cfg_dens64,
    input logic                       req_valid,
    input logic                       rsp_valid,
    input logic [1:0]                 rsp_status,
    input logic                       cmd_valid,
    input logic [1:0]                 cmd_op,
    input logic [RANK_W-1:0]          cmd_rank,
    input logic [SLOTS*NUM_RANKS-1:0] open_map
);
    logic              edo_open_any;
    logic              over_capacity;
    logic              last_close_rank;
    logic [RANK_W-1:0] last_rank;
    logic [SLOTS-1:0]  last_rank_flags;

    // Summarise open flags by rank type.
    always_comb begin
        edo_open_any  = 1'b0;
        over_capacity = 1'b0;
        for (int r = 0; r < NUM_RANKS; r++) begin
            if (!cfg_sdram[r]) begin
                edo_open_any  = edo_open_any | open_map[r*SLOTS];
                over_capacity = over_capacity | (|open_map[r*SLOTS+1 +: SLOTS-1]);
            end else if (!cfg_dens64[r]) begin
                over_capacity = over_capacity | (|open_map[r*SLOTS+2 +: SLOTS-2]);
            end
        end
    end

    // Remember a close-rank command to inspect its effect next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_close_rank <= 1'b0;
            last_rank       <= '0;
        end else begin
            last_close_rank <= cmd_valid && (cmd_op == 2'd3);
            last_rank       <= cmd_rank;
        end
    end

    // Slot flags of the rank that the previous command addressed.
    always_comb begin
        last_rank_flags = '0;
        for (int r = 0; r < NUM_RANKS; r++)
            if (last_rank == RANK_W'(r)) last_rank_flags = open_map[r*SLOTS +: SLOTS];
    end

    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (open_map == '0));

    a_r4_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    a_r4_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    a_r5_status_encoding: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_status != 2'd3));

    a_r6_bank_capacity: assert property (@(posedge clk) disable iff (!rst_n)
        !over_capacity);

    a_r7_edo_single_page: assert property (@(posedge clk) disable iff (!rst_n)
        edo_open_any |-> ($countones(open_map) == 1));

    a_r9_close_rank_empties: assert property (@(posedge clk) disable iff (!rst_n)
        last_close_rank |-> (last_rank_flags == '0));

endmodule

bind dram_pagemux dram_pagemux_chk #(.NUM_RANKS(NUM_RANKS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_sdram  (cfg_sdram),
    .cfg_dens64 (cfg_dens64),
    .req_valid  (req_valid),
    .rsp_valid  (rsp_valid),
    .rsp_status (rsp_status),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .cmd_rank   (cmd_rank),
    .open_map   (open_map)
);

// File: tb/test_dram_pagemux.sv
`timescale 1ns/1ps
module test_dram_pagemux;
    localparam int NR = 8;
    localparam int AW = 29;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NR-1:0] cfg_sdram  = 8'b1111_1100;
    logic [NR-1:0] cfg_dens64 = 8'b0111_0010;
    logic [2*NR-1:0] cfg_col  = 16'b10_01_00_10_01_00_00_00;
    logic          req_valid = 1'b0;
    logic [2:0]    req_rank = '0;
    logic [AW-1:0] req_addr = '0;
    logic          cmd_valid = 1'b0;
    logic [1:0]    cmd_op = '0;
    logic [2:0]    cmd_rank = '0;
    logic [AW-1:0] cmd_addr = '0;
    logic          rsp_valid;
    logic [1:0]    rsp_status;
    logic [1:0]    rsp_bank;
    logic [13:0]   rsp_ma_row, rsp_ma_col;
    logic [4*NR-1:0] open_map;

    always #2.5 clk = ~clk;

    dram_pagemux i_dram_pagemux (
        .clk(clk), .rst_n(rst_n), .cfg_sdram(cfg_sdram), .cfg_dens64(cfg_dens64),
        .cfg_col(cfg_col), .req_valid(req_valid), .req_rank(req_rank),
        .req_addr(req_addr), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_rank(cmd_rank), .cmd_addr(cmd_addr), .rsp_valid(rsp_valid),
        .rsp_status(rsp_status), .rsp_bank(rsp_bank), .rsp_ma_row(rsp_ma_row),
        .rsp_ma_col(rsp_ma_col), .open_map(open_map)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    // Reference page state.
    bit m_vld [NR][4];
    int m_row [NR][4];

    // Scoreboard queues.
    int    q_status[$];
    int    q_mar[$];
    int    q_mac[$];
    int    q_bank[$];
    string q_tag[$];

    function automatic int ncol(int r);
        if (!cfg_sdram[r]) return 8;
        return 8 + int'(cfg_col[2*r +: 2]);
    endfunction
    function automatic int nbank(int r);
        if (!cfg_sdram[r]) return 0;
        return cfg_dens64[r] ? 2 : 1;
    endfunction
    function automatic int nrow(int r);
        if (!cfg_sdram[r]) return cfg_dens64[r] ? 14 : 12;
        return cfg_dens64[r] ? 12 : 11;
    endfunction

    function automatic logic [AW-1:0] mk(int r, int row, int bank, int col);
        longint a;
        a = longint'(row);
        a = (a << nbank(r)) | longint'(bank);
        a = (a << ncol(r)) | longint'(col);
        return AW'(a << 3);
    endfunction

    task automatic split(input int r, input logic [AW-1:0] a,
                         output int row, output int bank, output int col);
        longint v;
        v    = longint'(a) >> 3;
        col  = int'(v & ((64'd1 << ncol(r)) - 1));
        v    = v >> ncol(r);
        bank = int'(v & ((64'd1 << nbank(r)) - 1));
        v    = v >> nbank(r);
        row  = int'(v & ((64'd1 << nrow(r)) - 1));
    endtask

    task automatic fail_line(string tag, string what, longint act, longint exp);
        n_fail++;
        $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    endtask

    // Driver: one cycle of stimulus, expected result pushed, model updated.
    task automatic cyc(bit rv, int rr, logic [AW-1:0] ra,
                       bit cv, int op, int cr, logic [AW-1:0] ca, string tag);
        int row, bank, col, st;
        @(negedge clk);
        req_valid = rv; req_rank = 3'(rr); req_addr = ra;
        cmd_valid = cv; cmd_op = 2'(op); cmd_rank = 3'(cr); cmd_addr = ca;
        if (rv) begin
            split(rr, ra, row, bank, col);
            if (!m_vld[rr][bank])           st = 0;
            else if (m_row[rr][bank] == row) st = 1;
            else                             st = 2;
            q_status.push_back(st);
            q_mar.push_back(row | (bank << 12));
            q_mac.push_back(col | (bank << 12));
            q_bank.push_back(bank);
            q_tag.push_back(tag);
        end
        if (cv) begin
            split(cr, ca, row, bank, col);
            case (op)
                1: begin
                    for (int r = 0; r < NR; r++)
                        for (int s = 0; s < 4; s++)
                            if (!cfg_sdram[cr] || !cfg_sdram[r]) m_vld[r][s] = 0;
                    m_vld[cr][bank] = 1;
                    m_row[cr][bank] = row;
                end
                2: m_vld[cr][bank] = 0;
                3: for (int s = 0; s < 4; s++) m_vld[cr][s] = 0;
                default: ;
            endcase
        end
        @(posedge clk);
        #1;
        req_valid = 0;
        cmd_valid = 0;
    endtask

    task automatic check_map(string tag);
        logic [4*NR-1:0] exp;
        @(negedge clk);
        for (int r = 0; r < NR; r++)
            for (int s = 0; s < 4; s++) exp[r*4+s] = m_vld[r][s];
        n_checks++;
        if (open_map !== exp) fail_line(tag, "open_map", longint'(open_map), longint'(exp));
    endtask

    // Monitor: compare each response against the oldest expectation.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            n_checks++;
            if (q_status.size() == 0) begin
                fail_line("R4", "unexpected response", 1, 0);
            end else begin
                int es, er, ec, eb;
                string t;
                es = q_status.pop_front(); er = q_mar.pop_front();
                ec = q_mac.pop_front(); eb = q_bank.pop_front(); t = q_tag.pop_front();
                if (rsp_status !== 2'(es))      fail_line(t, "status", longint'(rsp_status), longint'(es));
                else if (rsp_ma_row !== 14'(er)) fail_line(t, "ma_row", longint'(rsp_ma_row), longint'(er));
                else if (rsp_ma_col !== 14'(ec)) fail_line(t, "ma_col", longint'(rsp_ma_col), longint'(ec));
                else if (rsp_bank !== 2'(eb))    fail_line(t, "bank", longint'(rsp_bank), longint'(eb));
            end
        end
    end

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 100000);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
    end

    initial begin
        logic [AW-1:0] a;
        int unsigned lcg = 32'h1234_5678;
        for (int r = 0; r < NR; r++)
            for (int s = 0; s < 4; s++) begin m_vld[r][s] = 0; m_row[r][s] = 0; end

        repeat (3) @(negedge clk);
        n_checks++;
        if (rsp_valid !== 1'b0) fail_line("R1", "rsp_valid in reset", longint'(rsp_valid), 0);
        check_map("R1");
        @(negedge clk);
        rst_n = 1;

        // R1: first request after reset is idle.
        cyc(1, 2, mk(2, 5, 0, 3), 0, 0, 0, '0, "R1");

        // R6/R5: 16 Mb SDRAM rank, two banks.
        cyc(0, 0, '0, 1, 1, 2, mk(2, 100, 0, 0), "R6");
        check_map("R6");
        cyc(1, 2, mk(2, 100, 0, 17), 0, 0, 0, '0, "R5 hit");
        cyc(1, 2, mk(2, 101, 0, 17), 0, 0, 0, '0, "R5 miss");
        cyc(1, 2, mk(2, 100, 1, 17), 0, 0, 0, '0, "R5 idle");
        cyc(0, 0, '0, 1, 1, 2, mk(2, 77, 1, 0), "R6");
        check_map("R6 two banks");
        cyc(1, 2, mk(2, 100, 0, 1), 0, 0, 0, '0, "R6 bank0 kept");
        cyc(1, 2, mk(2, 77, 1, 1), 0, 0, 0, '0, "R6 bank1 hit");

        // R6: 64 Mb SDRAM rank, four banks.
        for (int b = 0; b < 4; b++) cyc(0, 0, '0, 1, 1, 4, mk(4, 300 + b, b, 0), "R6");
        check_map("R6 four banks");
        for (int b = 0; b < 4; b++) cyc(1, 4, mk(4, 300 + b, b, 1000), 0, 0, 0, '0, "R6 hit");

        // R9: close bank, no-op, close rank.
        cyc(0, 0, '0, 1, 2, 4, mk(4, 0, 2, 0), "R9");
        check_map("R9 close bank");
        cyc(0, 0, '0, 1, 0, 4, mk(4, 1, 1, 0), "R9");
        check_map("R9 no-op");
        cyc(1, 4, mk(4, 302, 2, 0), 0, 0, 0, '0, "R9 closed bank idle");
        cyc(0, 0, '0, 1, 3, 4, '0, "R9");
        check_map("R9 close rank");

        // R7: EDO open clears everything else.
        cyc(0, 0, '0, 1, 1, 0, mk(0, 2000, 0, 9), "R7");
        check_map("R7 EDO single page");
        cyc(1, 0, mk(0, 2000, 0, 200), 0, 0, 0, '0, "R7 hit");
        cyc(1, 2, mk(2, 100, 0, 1), 0, 0, 0, '0, "R7 sdram cleared");
        cyc(0, 0, '0, 1, 1, 1, mk(1, 16000, 0, 0), "R7");
        check_map("R7 EDO move");

        // R8: SDRAM open closes the EDO page.
        cyc(0, 0, '0, 1, 1, 3, mk(3, 9, 1, 0), "R8");
        check_map("R8 EDO cleared");
        cyc(1, 1, mk(1, 16000, 0, 0), 0, 0, 0, '0, "R8 EDO idle");

        // R10: same-cycle request and open.
        cyc(1, 5, mk(5, 1234, 3, 55), 1, 1, 5, mk(5, 1234, 3, 0), "R10 before");
        cyc(1, 5, mk(5, 1234, 3, 56), 0, 0, 0, '0, "R10 after");
        check_map("R11");

        // R2/R3: address split and bus values on every rank type.
        for (int r = 0; r < NR; r++)
            for (int k = 0; k < 4; k++) begin
                lcg = lcg * 32'd1664525 + 32'd1013904223;
                a = AW'(lcg);
                cyc(1, r, a, 0, 0, 0, '0, "R2 R3");
            end

        // Back-to-back requests for R4.
        for (int k = 0; k < 6; k++) cyc(1, 6, mk(6, k, k % 4, k), 0, 0, 0, '0, "R4");

        repeat (3) @(negedge clk);
        n_checks++;
        if (q_status.size() != 0) fail_line("R4", "missing responses", q_status.size(), 0);
        summary();
    end
endmodule